// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Contention Arbitration

The block is a synchronous memory with two independent ports of equal standing, called left and right. Each port has an enable, a write select, an address, write data and registered read data. On every clock the two addresses are compared. When both enabled ports point at the same word, the port that arrived first keeps the word. The other port sees its busy flag raised for as long as the collision lasts, and any write it attempts is dropped. After its busy flag falls, the losing port stays unable to write for a fixed number of guard cycles.

A strap input selects how busy is produced. As master, the local arbiter drives the busy outputs. As slave, the arbiter is bypassed: the busy outputs stay low and a busy input on each port, driven by an external master when several memories are cascaded, gates that port's writes. The guard interval applies in both modes.

When the addresses differ, both ports read and write in the same cycle without affecting each other. A read issued in one cycle presents its data after the next clock edge.

Top module: `dpmem_arb_top`

## Requirements
- R1: In master mode a busy output is high only while both enables are high and the two addresses are equal.
- R2: In master mode, while the addresses collide, exactly one busy output is high, and it rises in the same cycle the collision appears.
- R3: A port whose enable and address were already present in the previous cycle wins against a port whose request is new in this cycle. The new port receives busy.
- R4: When both ports present the colliding address for the first time in the same cycle, the left port wins and the right port receives busy.
- R5: Once a winner is chosen, it keeps the word for as long as the collision continues, even after both requests have become equally old.
- R6: Busy falls in the same cycle that the addresses stop matching or either enable drops.
- R7: With the strap low (slave), both busy outputs stay low whatever the addresses are. Each port's busy input then decides whether that port's writes are blocked.
- R8: A write issued while that port's busy is high leaves the memory word unchanged.
- R9: After a port's busy falls, writes from that port are blocked for HOLD_CYC cycles (default 2). The first write accepted is the one issued HOLD_CYC+1 cycles after the last busy cycle.
- R10: With different addresses, both ports read and write in the same cycle. Read data appears one clock after the read is issued, and a word written at one edge is returned by a read issued in the next cycle.
- R11: The ports are symmetric: the right port can win against a later left writer, and the left port then receives busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1: local arbiter drives busy; 0: busy taken from inputs |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write select (1 write, 0 read) |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, registered |
| l_busy_in | input | 1 | Left busy from external master (slave mode) |
| l_busy_out | output | 1 | Left busy from local arbiter (master mode) |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write select |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, registered |
| r_busy_in | input | 1 | Right busy from external master (slave mode) |
| r_busy_out | output | 1 | Right busy from local arbiter (master mode) |

## Verification
Two functions can land in the same cycle: arbitration and write gating. A late write to the word another port is holding must raise busy combinationally in that same cycle and must also be suppressed at that cycle's edge. Tests provoke this by placing one port on an address and, one cycle later or in the same cycle, sending the other port a write to that address. The busy flags are checked mid-cycle, and the word is read back afterwards against a reference copy. The guard interval is judged the same way: writes are placed one and two cycles after release, and again just past the interval.

// File: rtl/dpmem_pkg.sv
package dpmem_pkg;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // Arrival rule: an older request beats a new one; equal age goes left.
  function automatic side_e pick_winner(input logic old_l, input logic old_r);
    return (old_r && !old_l) ? SIDE_R : SIDE_L;
  endfunction

  // Guard countdown: reload while busy, then count down to zero.
  function automatic int unsigned guard_next(input logic busy, input int unsigned cnt,
                                             input int unsigned reload);
    if (busy) return reload;
    if (cnt != 0) return cnt - 1;
    return 0;
  endfunction

endpackage

// File: rtl/dpmem_collide.sv
module dpmem_collide
  import dpmem_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  output logic          match,
  output logic          busy_l,
  output logic          busy_r
);

  logic          prev_l_en, prev_r_en;
  logic [AW-1:0] prev_l_addr, prev_r_addr;
  logic          lock_valid;
  side_e         lock_side;
  logic          old_l, old_r;
  side_e         fresh_side, win_side;

  assign match  = l_en && r_en && (l_addr == r_addr);
  assign old_l  = l_en && prev_l_en && (l_addr == prev_l_addr);
  assign old_r  = r_en && prev_r_en && (r_addr == prev_r_addr);
  assign fresh_side = pick_winner(old_l, old_r);
  assign win_side   = lock_valid ? lock_side : fresh_side;

  assign busy_l = master && match && (win_side == SIDE_R);
  assign busy_r = master && match && (win_side == SIDE_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_l_en   <= 1'b0;
      prev_r_en   <= 1'b0;
      prev_l_addr <= '0;
      prev_r_addr <= '0;
      lock_valid  <= 1'b0;
      lock_side   <= SIDE_L;
    end else begin
      prev_l_en   <= l_en;
      prev_r_en   <= r_en;
      prev_l_addr <= l_addr;
      prev_r_addr <= r_addr;
      lock_valid  <= master && match;
      lock_side   <= win_side;
    end
  end

  AST_BUSY_WITHOUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l || busy_r) |-> (l_en && r_en && (l_addr == r_addr))); // R1

  AST_OLD_BEATS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && !lock_valid && old_l && !old_r) |-> (busy_r && !busy_l)); // R3

  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (master && match && $past(master && match && busy_l)) |-> busy_l); // R5

  AST_RELEASE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> (!busy_l && !busy_r)); // R6

endmodule

// File: rtl/dpmem_wgate.sv
module dpmem_wgate
  import dpmem_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic wr_req,
  output logic wr_ok
);

  localparam int CW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

  logic [CW-1:0] guard_cnt;
  logic          guarded;

  assign guarded = busy || (guard_cnt != '0);
  assign wr_ok   = wr_req && !guarded;

  always_ff @(posedge clk) begin
    if (!rst_n) guard_cnt <= '0;
    else        guard_cnt <= CW'(guard_next(busy, int'(guard_cnt), HOLD_CYC));
  end

  AST_NO_WRITE_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ok); // R8

  AST_GUARD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !wr_ok); // R9

endmodule

// File: rtl/dpmem_arb_top.sv
module dpmem_arb_top
  import dpmem_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_in,
  output logic          l_busy_out,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_in,
  output logic          r_busy_out
);

  localparam int DEPTH = 1 << AW;

  logic          match;
  logic          arb_busy_l, arb_busy_r;
  logic [1:0]    busy_eff, wr_req, wr_ok;
  logic [DW-1:0] mem [DEPTH];

  dpmem_collide #(.AW(AW)) u_collide (
    .clk    (clk),
    .rst_n  (rst_n),
    .master (is_master),
    .l_en   (l_en),
    .l_addr (l_addr),
    .r_en   (r_en),
    .r_addr (r_addr),
    .match  (match),
    .busy_l (arb_busy_l),
    .busy_r (arb_busy_r)
  );

  assign l_busy_out  = arb_busy_l;
  assign r_busy_out  = arb_busy_r;
  assign busy_eff[0] = is_master ? arb_busy_l : l_busy_in;
  assign busy_eff[1] = is_master ? arb_busy_r : r_busy_in;
  assign wr_req[0]   = l_en && l_we;
  assign wr_req[1]   = r_en && r_we;

  for (genvar p = 0; p < 2; p++) begin : g_gate
    dpmem_wgate #(.HOLD_CYC(HOLD_CYC)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy   (busy_eff[p]),
      .wr_req (wr_req[p]),
      .wr_ok  (wr_ok[p])
    );
  end

  // Right write first so that, in slave mode with no busy, left wins a same-word write.
  always_ff @(posedge clk) begin
    if (wr_ok[1]) mem[r_addr] <= r_wdata;
    if (wr_ok[0]) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_en && !l_we) l_rdata <= mem[l_addr];
      if (r_en && !r_we) r_rdata <= mem[r_addr];
    end
  end

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && match) |-> (l_busy_out != r_busy_out)); // R2

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!l_busy_out && !r_busy_out)); // R7

  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && match) |-> !(wr_ok[0] && wr_ok[1])); // R8

endmodule

// File: tb/sim_dpmem_arb_top.sv
`timescale 1ns/1ps
module sim_dpmem_arb_top;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int HOLD = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_in = 0, r_busy_in = 0;
  logic l_busy_out, r_busy_out;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  dpmem_arb_top #(.AW(AW), .DW(DW), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    l_en = 0; l_we = 0; r_en = 0; r_we = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic lread(input logic [AW-1:0] a);
    l_en = 1; l_we = 0; l_addr = a;
  endtask
  task automatic rread(input logic [AW-1:0] a);
    r_en = 1; r_we = 0; r_addr = a;
  endtask
  task automatic lwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_en = 1; l_we = 1; l_addr = a; l_wdata = d;
  endtask
  task automatic rwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_en = 1; r_we = 1; r_addr = a; r_wdata = d;
  endtask

  task automatic t_reset();
    chk("R1 reset l_busy_out", l_busy_out, 0);
    chk("R1 reset r_busy_out", r_busy_out, 0);
    chk("R10 reset l_rdata", l_rdata, 0);
    chk("R10 reset r_rdata", r_rdata, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      lwrite(i[AW-1:0], DW'(i * 3 + 1));
      model[i] = DW'(i * 3 + 1);
      step();
    end
    idle(1);
  endtask

  task automatic t_independent();
    lwrite(4'd2, 8'hA5); rread(4'd5); #1;
    chk("R1 no busy on differing addr", {l_busy_out, r_busy_out}, 0);
    step();
    chk("R10 right read beside left write", r_rdata, model[5]);
    model[2] = 8'hA5;
    lread(4'd2); rwrite(4'd7, 8'h3C);
    step();
    chk("R10 left sees word written last edge", l_rdata, 8'hA5);
    model[7] = 8'h3C;
    idle(1);
    rread(4'd7);
    step();
    chk("R10 right reads own write", r_rdata, 8'h3C);
    idle(1);
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] la, ra;
      logic lw, rw;
      logic [DW-1:0] ld, rd, le, re;
      la = AW'($urandom % DEPTH);
      ra = AW'((int'(la) + 1 + ($urandom % (DEPTH - 1))) % DEPTH);
      lw = 1'($urandom); rw = 1'($urandom);
      ld = DW'($urandom); rd = DW'($urandom);
      le = model[la]; re = model[ra];
      l_en = 1; l_we = lw; l_addr = la; l_wdata = ld;
      r_en = 1; r_we = rw; r_addr = ra; r_wdata = rd;
      #1;
      chk("R1 random traffic no busy", {l_busy_out, r_busy_out}, 0);
      step();
      if (!lw) chk("R10 random left read", l_rdata, le);
      if (!rw) chk("R10 random right read", r_rdata, re);
      if (lw) model[la] = ld;
      if (rw) model[ra] = rd;
    end
    idle(1);
  endtask

  task automatic t_left_first();
    idle(1);
    lread(4'd9);
    step();
    rwrite(4'd9, 8'hEE); #1;
    chk("R3 late right gets busy", r_busy_out, 1);
    chk("R2 early left not busy", l_busy_out, 0);
    step();
    idle(1);
    lread(4'd9);
    step();
    chk("R8 blocked right write left word", l_rdata, model[9]);
    idle(1);
  endtask

  task automatic t_right_first();
    idle(1);
    rread(4'd8);
    step();
    lwrite(4'd8, 8'hDD); #1;
    chk("R11 late left gets busy", l_busy_out, 1);
    chk("R11 early right not busy", r_busy_out, 0);
    step();
    idle(1);
    rread(4'd8);
    step();
    chk("R11 blocked left write", r_rdata, model[8]);
    idle(1);
  endtask

  task automatic t_tie();
    idle(1);
    lread(4'd6); rwrite(4'd6, 8'h77); #1;
    chk("R4 tie right busy", r_busy_out, 1);
    chk("R4 tie left free", l_busy_out, 0);
    step();
    idle(1);
    lread(4'd6);
    step();
    chk("R4 tie write dropped", l_rdata, model[6]);
    idle(1);
  endtask

  task automatic t_lock();
    idle(1);
    rread(4'd10);
    step();
    lread(4'd10); #1;
    chk("R3 left late busy", l_busy_out, 1);
    step();
    #1;
    chk("R5 winner held left busy", l_busy_out, 1);
    chk("R5 winner held right free", r_busy_out, 0);
    step();
    #1;
    chk("R5 winner held third cycle", l_busy_out, 1);
    r_addr = 4'd11; #1;
    chk("R6 busy drops on address change", {l_busy_out, r_busy_out}, 0);
    step();
    r_addr = 4'd10; r_en = 0; #1;
    chk("R6 busy low with right disabled", {l_busy_out, r_busy_out}, 0);
    idle(1);
  endtask

  task automatic t_guard();
    // first write right after release is dropped
    idle(HOLD + 1);
    lread(4'd12);
    step();
    rwrite(4'd12, 8'h51); #1;
    chk("R2 collision busy", r_busy_out, 1);
    step();
    l_en = 0; rwrite(4'd12, 8'h51); #1;
    chk("R6 released", r_busy_out, 0);
    step();
    rread(4'd12);
    step();
    chk("R9 write one cycle after release dropped", r_rdata, model[12]);
    // second cycle dropped, third accepted
    idle(HOLD + 1);
    lread(4'd12);
    step();
    rwrite(4'd12, 8'h52);
    step();
    idle(1);
    rwrite(4'd12, 8'h52);
    step();
    rread(4'd12);
    step();
    chk("R9 write two cycles after release dropped", r_rdata, model[12]);
    rwrite(4'd12, 8'h54);
    step();
    rread(4'd12);
    step();
    model[12] = 8'h54;
    chk("R9 write after guard accepted", r_rdata, 8'h54);
    idle(1);
  endtask

  task automatic t_slave();
    is_master = 0;
    idle(HOLD + 1);
    lread(4'd13); rwrite(4'd13, 8'h66); #1;
    chk("R7 slave never drives busy", {l_busy_out, r_busy_out}, 0);
    step();
    model[13] = 8'h66;
    idle(1);
    lread(4'd13);
    step();
    chk("R7 slave no arbitration, write lands", l_rdata, 8'h66);
    idle(1);
    r_busy_in = 1; rwrite(4'd13, 8'h67);
    step();
    r_busy_in = 0; rread(4'd13);
    step();
    chk("R7 R8 busy input blocks right write", r_rdata, 8'h66);
    idle(HOLD + 1);
    l_busy_in = 1; lwrite(4'd1, 8'h70);
    step();
    l_busy_in = 0;
    idle(HOLD);
    lwrite(4'd1, 8'h71);
    step();
    lread(4'd1);
    step();
    model[1] = 8'h71;
    chk("R7 R9 left write accepted after guard", l_rdata, 8'h71);
    idle(1);
    is_master = 1;
    idle(1);
  endtask

  initial begin
    #1;
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_fill();
    t_independent();
    t_left_first();
    t_right_first();
    t_tie();
    t_lock();
    t_guard();
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule